// File: doc/BRIEF.md
# Signed Array Multiplier with Weighted Cells

This block multiplies two W-bit two's complement operands and returns the full 2W-bit two's complement product, with no clock and no state. It is a regular array: an AND matrix forms every partial-product bit, W-1 carry-save rows fold one multiplier bit's partial-product row each into the running sum, and a single ripple row resolves the upper half of the result. The low product bits leave the array one per row, from the rightmost cell.

Partial-product bits that pair exactly one operand sign bit with a non-sign bit have weight -2^k. These bits are not rewritten into positive form, and no fix-up constant is added. Every wire in the array instead carries a fixed polarity. Each adder cell is built for the number of negative inputs it receives, and its sum and carry leave with the polarity that keeps the weighted value exact. The cell kinds are set at elaboration from row and column indices, so one description covers any W of two or more.

The block is meant for datapaths that need a signed product in one combinational step from a layout-friendly structure. W defaults to 5.

Top module: `wsa_mult`

## Requirements
- R1: For every pair of W-bit two's complement operands, p_o holds their exact signed product as a 2W-bit two's complement value.
- R2: The most negative operand times itself gives +2^(2W-2): only bit 2W-2 of p_o is set.
- R3: The most negative operand times -1 (all ones) gives +2^(W-1), with bits 2W-1 down to W all zero.
- R4: If either operand is zero, every bit of p_o is zero.
- R5: If both operands are nonzero, p_o bit 2W-1 equals the XOR of the two operand sign bits (bit W-1 of each).
- R6: The low W bits of p_o equal the low W bits of the unsigned product of the two operand bit patterns.
- R7: Swapping a_i and b_i leaves p_o unchanged, even though the array treats its two operands differently.
- R8: The same description elaborated with W = 8 also meets R1.
- R9: With b_i equal to 1, p_o equals a_i sign-extended to 2W bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Multiplicand, two's complement |
| b_i | input | W | Multiplier, two's complement; bit j selects partial-product row j |
| p_o | output | 2W | Product, two's complement |

## Verification
At W = 5 the sweep covers all 1024 operand pairs. This separates faults in the low half, which the rows finalise and which must match the unsigned pattern product, from faults in the upper half, where the negative-weight bits and the borrow chain of the last row act. Zero operands, multiplication by one and the sign rule isolate the cells fed by the sign bits. The most negative operand squared, and times -1, drive the largest magnitudes through the top columns. Storing every result and comparing swapped pairs exposes any fault that breaks the asymmetric row and column roles. A W = 8 instance run with corner and random pairs confirms that the polarity formulas hold beyond the default size.

// File: rtl/wsa_pkg.sv
package wsa_pkg;

  // Adder cell kinds, by count of negatively weighted inputs.
  typedef enum logic [1:0] {
    CELL_POS3 = 2'd0,  // no negative input
    CELL_NEG1 = 2'd1,  // one negative: carry +2, sum -1
    CELL_NEG2 = 2'd2,  // two negative: carry -2, sum +1
    CELL_NEG3 = 2'd3   // all negative: carry -2, sum -1
  } cell_kind_e;

  function automatic cell_kind_e kind_of(input int unsigned n_neg);
    case (n_neg)
      0:       return CELL_POS3;
      1:       return CELL_NEG1;
      2:       return CELL_NEG2;
      default: return CELL_NEG3;
    endcase
  endfunction

endpackage

// File: rtl/wsa_pp_gen.sv
module wsa_pp_gen #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W*W-1:0] pp_o
);

  // pp_o[j*W+i] = a[i] & b[j]
  for (genvar j = 0; j < W; j++) begin : g_row
    for (genvar i = 0; i < W; i++) begin : g_col
      assign pp_o[j*W+i] = a_i[i] & b_i[j];
    end
  end

endmodule

// File: rtl/wsa_cell.sv
module wsa_cell
  import wsa_pkg::*;
#(
  parameter bit X_NEG = 1'b0,
  parameter bit Y_NEG = 1'b0,
  parameter bit Z_NEG = 1'b0
) (
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output logic s_o,
  output logic c_o
);

  localparam int unsigned NNEG    = int'(X_NEG) + int'(Y_NEG) + int'(Z_NEG);
  localparam cell_kind_e  KIND    = kind_of(NNEG);
  localparam bit          MAJ_NEG = (NNEG >= 2);

  logic xm, ym, zm;

  assign s_o = x_i ^ y_i ^ z_i;

  if (KIND == CELL_POS3 || KIND == CELL_NEG3) begin : g_uniform
    assign xm = x_i;
    assign ym = y_i;
    assign zm = z_i;
  end else begin : g_mixed
    // invert inputs whose polarity is in the minority
    assign xm = x_i ^ (X_NEG != MAJ_NEG);
    assign ym = y_i ^ (Y_NEG != MAJ_NEG);
    assign zm = z_i ^ (Z_NEG != MAJ_NEG);
  end

  assign c_o = (xm & ym) | (xm & zm) | (ym & zm);

endmodule

// File: rtl/wsa_final_row.sv
module wsa_final_row #(
  parameter int unsigned W = 5
) (
  input  logic [W-2:0] u_i,      // positive sums, columns W..2W-2
  input  logic [W-2:0] c_i,      // negative carries, columns W..2W-2
  input  logic         top_c_i,  // positive carry, column 2W-1
  output logic [W-1:0] hi_o
);

  // negatively weighted borrow chain
  logic [W-1:0] bw;

  assign bw[0] = 1'b0;

  for (genvar m = 0; m < W-1; m++) begin : g_col
    wsa_cell #(
      .X_NEG(1'b0),
      .Y_NEG(1'b1),
      .Z_NEG(1'b1)
    ) u_cell (
      .x_i(u_i[m]),
      .y_i(c_i[m]),
      .z_i(bw[m]),
      .s_o(hi_o[m]),
      .c_o(bw[m+1])
    );
  end

  // top column: the carry out would weigh 2^(2W) and falls outside the result
  assign hi_o[W-1] = top_c_i ^ bw[W-1];

endmodule

// File: rtl/wsa_mult.sv
module wsa_mult #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);

  localparam int unsigned PW = 2 * W;

  logic [W*W-1:0]        pp;
  logic [W-1:0][W-1:0]   rs;  // rs[j][i]: sum of row j, column i+j
  logic [W-1:0][W-1:0]   rc;  // rc[j][i]: carry of row j into column i+j+1

  wsa_pp_gen #(.W(W)) u_pp (
    .a_i (a_i),
    .b_i (b_i),
    .pp_o(pp)
  );

  assign rs[0] = pp[W-1:0];
  assign rc[0] = '0;

  for (genvar j = 1; j < W; j++) begin : g_row
    for (genvar i = 0; i < W; i++) begin : g_cell
      // exactly one sign-bit factor gives a negative partial product
      localparam bit PP_NEG = ((i == W-1) != (j == W-1));
      // sums left at column W-1 and above stay negative until the last row
      localparam bit U_NEG  = (i < W-1) && (i + j >= W-1);

      logic u_in;

      if (i < W-1) begin : g_up
        assign u_in = rs[j-1][i+1];
      end else begin : g_edge
        assign u_in = 1'b0;
      end

      wsa_cell #(
        .X_NEG(PP_NEG),
        .Y_NEG(U_NEG),
        .Z_NEG(1'b0)
      ) u_cell (
        .x_i(pp[j*W+i]),
        .y_i(u_in),
        .z_i(rc[j-1][i]),
        .s_o(rs[j][i]),
        .c_o(rc[j][i])
      );
    end
  end

  for (genvar j = 0; j < W; j++) begin : g_low
    assign p_o[j] = rs[j][0];
  end

  wsa_final_row #(.W(W)) u_fin (
    .u_i    (rs[W-1][W-1:1]),
    .c_i    (rc[W-1][W-2:0]),
    .top_c_i(rc[W-1][W-1]),
    .hi_o   (p_o[PW-1:W])
  );

endmodule

// File: rtl/wsa_mult_chk.sv
module wsa_mult_chk #(
  parameter int unsigned W = 5
) (
  input logic [W-1:0]   a_i,
  input logic [W-1:0]   b_i,
  input logic [2*W-1:0] p_o
);

  localparam logic [2*W-1:0] MIN_SQ = {2'b01, {(2*W-2){1'b0}}};
  localparam logic [W-1:0]   MIN_OP = {1'b1, {(W-1){1'b0}}};

  logic signed [2*W-1:0] exp_p;
  logic        [W-1:0]   exp_lo;

  always_comb begin
    exp_p  = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});
    exp_lo = a_i * b_i;

    // R1
    prod_match_chk: assert (p_o == exp_p)
      else $error("product mismatch a=%0h b=%0h p=%0h", a_i, b_i, p_o);

    // R6
    low_half_chk: assert (p_o[W-1:0] == exp_lo)
      else $error("low half mismatch a=%0h b=%0h", a_i, b_i);

    // R4
    if (a_i == '0 || b_i == '0) begin
      zero_operand_chk: assert (p_o == '0)
        else $error("zero operand gave %0h", p_o);
    end

    // R5
    if (a_i != '0 && b_i != '0) begin
      sign_rule_chk: assert (p_o[2*W-1] == (a_i[W-1] ^ b_i[W-1]))
        else $error("sign bit wrong a=%0h b=%0h", a_i, b_i);
    end

    // R2
    if (a_i == MIN_OP && b_i == MIN_OP) begin
      min_square_chk: assert (p_o == MIN_SQ)
        else $error("min squared gave %0h", p_o);
    end
  end

endmodule

bind wsa_mult wsa_mult_chk #(.W(W)) u_chk (
  .a_i(a_i),
  .b_i(b_i),
  .p_o(p_o)
);

// File: tb/wsa_mult_tb_top.sv
module wsa_mult_tb_top;

  localparam int unsigned W  = 5;
  localparam int unsigned WB = 8;
  localparam int unsigned NA = 1 << W;

  logic clk    = 1'b0;
  logic rst_ni = 1'b0;

  always #10 clk = ~clk;

  logic [W-1:0]    a, b;
  logic [2*W-1:0]  p;
  logic [WB-1:0]   a8, b8;
  logic [2*WB-1:0] p8;

  int n_chk  = 0;
  int n_fail = 0;

  logic [2*W-1:0] res_q [NA*NA];

  wsa_mult #(.W(W)) dut_i (
    .a_i(a),
    .b_i(b),
    .p_o(p)
  );

  wsa_mult #(.W(WB)) dut_w8_i (
    .a_i(a8),
    .b_i(b8),
    .p_o(p8)
  );

  function automatic logic [2*W-1:0] ref5(input logic [W-1:0] x, input logic [W-1:0] y);
    longint sx, sy, pr;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    pr = sx * sy;
    return pr[2*W-1:0];
  endfunction

  function automatic logic [2*WB-1:0] ref8(input logic [WB-1:0] x, input logic [WB-1:0] y);
    longint sx, sy, pr;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    pr = sx * sy;
    return pr[2*WB-1:0];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive5(input logic [W-1:0] x, input logic [W-1:0] y);
    @(posedge clk);
    a = x;
    b = y;
    @(negedge clk);
  endtask

  task automatic drive8(input logic [WB-1:0] x, input logic [WB-1:0] y);
    @(posedge clk);
    a8 = x;
    b8 = y;
    @(negedge clk);
    chk("R8 width 8 product", 64'(p8), 64'(ref8(x, y)));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual still running expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] mn;
    mn = {1'b1, {(W-1){1'b0}}};
    a  = '0;
    b  = '0;
    a8 = '0;
    b8 = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R4 reset state zero product", 64'(p), 64'(0));

    // exhaustive sweep at W = 5
    for (int ai = 0; ai < NA; ai++) begin
      for (int bi = 0; bi < NA; bi++) begin
        logic [W-1:0] x, y, lo;
        x  = W'(ai);
        y  = W'(bi);
        lo = W'(ai * bi);
        drive5(x, y);
        chk("R1 signed product", 64'(p), 64'(ref5(x, y)));
        chk("R6 low half", 64'(p[W-1:0]), 64'(lo));
        res_q[ai*NA+bi] = p;
        if (ai == 0 || bi == 0)
          chk("R4 zero operand", 64'(p), 64'(0));
        else
          chk("R5 sign bit", 64'(p[2*W-1]), 64'(x[W-1] ^ y[W-1]));
        if (bi == 1)
          chk("R9 times one", 64'(p), 64'({{W{x[W-1]}}, x}));
      end
    end

    // R7: swapped operands
    for (int ai = 0; ai < NA; ai++) begin
      for (int bi = ai + 1; bi < NA; bi++) begin
        chk("R7 swap", 64'(res_q[ai*NA+bi]), 64'(res_q[bi*NA+ai]));
      end
    end

    // R2
    drive5(mn, mn);
    chk("R2 min squared", 64'(p), 64'(1) << (2*W-2));

    // R3
    drive5(mn, '1);
    chk("R3 min times minus one", 64'(p), 64'(1) << (W-1));

    // R8: corners then random pairs at W = 8
    drive8(8'h80, 8'h80);
    drive8(8'h80, 8'hff);
    drive8(8'h7f, 8'h80);
    drive8(8'h7f, 8'h7f);
    drive8(8'hff, 8'hff);
    drive8(8'h00, 8'h95);
    for (int k = 0; k < 400; k++) begin
      drive8(WB'($urandom), WB'($urandom));
    end

    finish_run();
  end

endmodule